// File: doc/BRIEF.md
# Self-Reloading Interval Timer with Sticky Interrupt

This block counts prescaler tick pulses down from a programmed interval. When the count runs out, it raises a sticky expiry flag and starts the next interval on the same clock edge, so the period repeats with no software action. Software sets the interval and an interrupt enable, reads the flag, and clears the flag by writing a one to it. The interrupt line is high while the flag and the enable are both set.

The block has two reset paths. The asynchronous hardware reset returns every register to its idle state. The software reset pulse and the stop pulse only restart the current interval, and they leave the flag alone. All pins are plain control and status pins. No stream data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `swtmr_top`

## Requirements
- R1: While `rst_n` is low, and after it rises, the interval field reads 0, enable reads 0, the flag reads 0, the count reads 64 (with the default 6-bit interval) and `irq` is 0.
- R2: In a cycle with `tick`=1 and no restart, the count drops by one on the next edge. With `tick`=0 the count holds.
- R3: A tick that arrives while the count is 1 sets the flag and loads the interval into the count on the same edge. The count never reads 0.
- R4: The interval is written at address 0, bits [5:0], and reads back there. A new value does not change the running count; it takes effect at the next reload.
- R5: An interval field of 0 gives a 64-tick period.
- R6: At address 1, bit 1 is the interrupt enable (read/write). `irq` is 1 exactly when the flag and the enable are both 1.
- R7: At address 1, bit 0 is the flag. Writing 1 there clears the flag. Writing 0 leaves it unchanged.
- R8: If an expiry and a clear-write fall in the same cycle, the flag ends up set.
- R9: A `sw_rst` or `stop` pulse loads the interval into the count. A tick in that cycle is ignored. The flag, the enable and the interval are unchanged.
- R10: Reading address 2 returns the current count. Address 3 reads as 0. `rd_data` follows `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Software reset pulse: restarts the interval |
| stop | input | 1 | Stop command pulse: restarts the interval |
| tick | input | 1 | Prescaler tick; one decrement per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the zero-interval case. A design that treats an interval of 0 literally would either stall or expire on every tick, and the 64-tick period check catches both. It lines a clear-write up with the exact expiry edge; a design where the clear wins would drop that event and leave `irq` low. It also restarts with `sw_rst` and `stop` while the flag is set and a tick is pending. That exposes a design that lets those pulses clear the flag, or that still applies the tick. Finally, it rewrites the interval partway through a count. A design that loads the new value into the count at once diverges from the reference on the following cycles.

// File: rtl/swtmr_pkg.sv
package swtmr_pkg;
  // Register addresses
  typedef enum logic [1:0] {
    ADDR_INTERVAL = 2'd0,
    ADDR_CTRL     = 2'd1,
    ADDR_COUNT    = 2'd2,
    ADDR_SPARE    = 2'd3
  } reg_addr_e;

  // Bit positions in the control register
  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
endpackage

// File: rtl/swtmr_regs.sv
module swtmr_regs
  import swtmr_pkg::*;
#(
  parameter int RLD_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RLD_W-1:0]  interval_q,
  output logic              enable_q,
  output logic              clr_req
);
  logic wr_int, wr_ctl;
  logic unused_hi;

  assign wr_int    = wr_en && (wr_addr == ADDR_INTERVAL);
  assign wr_ctl    = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_req   = wr_ctl && wr_data[CTRL_FLAG_BIT];
  assign unused_hi = ^wr_data[DATA_W-1:RLD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_q <= '0;
      enable_q   <= 1'b0;
    end else begin
      if (wr_int) interval_q <= wr_data[RLD_W-1:0];
      if (wr_ctl) enable_q   <= wr_data[CTRL_EN_BIT];
    end
  end

  assert_interval_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_int |=> $stable(interval_q));
  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(enable_q));
endmodule

// File: rtl/swtmr_counter.sv
module swtmr_counter #(
  parameter int RLD_W = 6,
  localparam int CNT_W = RLD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [RLD_W-1:0] interval_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RLD_W;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] load_val;

  // An interval of zero means the full 2^RLD_W ticks
  assign load_val = (interval_q == '0) ? FULL : {1'b0, interval_q};
  assign expire   = tick && !restart && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= FULL;
    else if (restart)  cnt_q <= load_val;
    else if (tick)     cnt_q <= (cnt_q == ONE) ? load_val : cnt_q - ONE;
  end

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(load_val));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == $past(load_val));
endmodule

// File: rtl/swtmr_status.sv
module swtmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic flag_q
);
  // Set has priority over the write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr_req) |=> flag_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !flag_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !expire) |=> flag_q == $past(flag_q));
endmodule

// File: rtl/swtmr_top.sv
module swtmr_top
  import swtmr_pkg::*;
#(
  parameter int RLD_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              stop,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W = RLD_W + 1;

  logic [RLD_W-1:0] interval_q;
  logic             enable_q, clr_req, flag_q, expire, restart;
  logic [CNT_W-1:0] cnt_q;

  assign restart = sw_rst || stop;

  swtmr_regs #(.RLD_W(RLD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .interval_q(interval_q), .enable_q(enable_q),
    .clr_req(clr_req)
  );

  swtmr_counter #(.RLD_W(RLD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .interval_q(interval_q), .cnt_q(cnt_q), .expire(expire)
  );

  swtmr_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
    .flag_q(flag_q)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_INTERVAL: rd_data = DATA_W'(interval_q);
      ADDR_CTRL:     rd_data = DATA_W'({enable_q, flag_q});
      ADDR_COUNT:    rd_data = DATA_W'(cnt_q);
      default:       rd_data = '0;
    endcase
  end

  assign irq = flag_q && enable_q;

  assert_restart_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !(wr_en && wr_addr == ADDR_CTRL)) |=> flag_q == $past(flag_q));
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> enable_q);
endmodule

// File: tb/swtmr_top_test.sv
module swtmr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0, stop = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  int compared = 0, mismatched = 0;
  string tag_now = "R1", tag_prev = "R1";

  // Behavioural reference state
  int m_int = 0, m_cnt = 64, m_flag = 0, m_en = 0;

  always #10 clk = ~clk;

  swtmr_top uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop(stop), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic int period(int v);
    return (v == 0) ? 64 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_int = 0; m_cnt = 64; m_flag = 0; m_en = 0;
    end else begin
      int old_int;
      bit hit;
      old_int = m_int;
      hit = tick && !(sw_rst || stop) && (m_cnt == 1);
      if (sw_rst || stop)  m_cnt = period(old_int);
      else if (tick)       m_cnt = (m_cnt == 1) ? period(old_int) : m_cnt - 1;
      if (hit) m_flag = 1;
      else if (wr_en && wr_addr == 2'd1 && wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 2'd1) m_en = wr_data[1];
      if (wr_en && wr_addr == 2'd0) m_int = wr_data[5:0];
    end
  end

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return m_int;
      2'd1: return m_en * 2 + m_flag;
      2'd2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    int exp_rd, exp_irq;
    exp_rd  = model_read(rd_addr);
    exp_irq = m_flag & m_en;
    compared++;
    if (int'(rd_data) != exp_rd) begin
      mismatched++;
      $display("FAIL %s rd_data addr=%0d actual=%0d expected=%0d", tag_prev, rd_addr, rd_data, exp_rd);
    end
    compared++;
    if (int'(irq) != exp_irq) begin
      mismatched++;
      $display("FAIL %s irq actual=%0d expected=%0d", tag_prev, irq, exp_irq);
    end
  endtask

  // Compare at the falling edge, then drive the inputs for the next rising edge
  task automatic cyc(input bit tk, input bit sr, input bit sp, input bit we,
                     input logic [1:0] wa, input logic [7:0] wd,
                     input logic [1:0] ra, input string tg);
    @(negedge clk);
    compare();
    tag_prev = tag_now;
    tag_now = tg;
    tick = tk; sw_rst = sr; stop = sp; wr_en = we;
    wr_addr = wa; wr_data = wd; rd_addr = ra;
  endtask

  task automatic idle(input logic [1:0] ra, input string tg);
    cyc(0, 0, 0, 0, 2'd0, 8'd0, ra, tg);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    for (int i = 0; i < 3; i++) idle(2'(i), "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle(2'(i), "R1");
    // R2: irregular tick pattern
    for (int i = 0; i < 20; i++) cyc((i % 3) != 0, 0, 0, 0, 2'd0, 8'd0, 2'd2, "R2");
    // R5: zero interval gives 64 ticks
    for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, (i % 2) ? 2'd1 : 2'd2, "R5");
    // R6: enable raises irq
    cyc(0, 0, 0, 1, 2'd1, 8'h02, 2'd1, "R6");
    idle(2'd1, "R6"); idle(2'd1, "R6");
    // R7: writing 0 to the flag has no effect, then disable/enable
    cyc(0, 0, 0, 1, 2'd1, 8'h00, 2'd1, "R7");
    idle(2'd1, "R7");
    cyc(0, 0, 0, 1, 2'd1, 8'h02, 2'd1, "R7");
    cyc(0, 0, 0, 1, 2'd1, 8'h03, 2'd1, "R7");
    idle(2'd1, "R7"); idle(2'd1, "R7");
    // R4: rewrite the interval mid-count
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, 2'd2, "R4");
    cyc(1, 0, 0, 1, 2'd0, 8'hC5, 2'd0, "R4");
    for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, (i % 3 == 0) ? 2'd1 : 2'd2, "R4");
    // R3: short period of 3, back-to-back expiries
    cyc(0, 0, 0, 1, 2'd0, 8'd3, 2'd0, "R3");
    cyc(1, 0, 0, 1, 2'd1, 8'h03, 2'd2, "R3");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, (i % 2) ? 2'd1 : 2'd2, "R3");
    // R8: clear-write on the exact expiry edge
    cyc(1, 0, 0, 1, 2'd1, 8'h03, 2'd1, "R8");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8 && m_cnt != 1; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, 2'd2, "R8");
      cyc(1, 0, 0, 1, 2'd1, 8'h03, 2'd1, "R8");
      idle(2'd1, "R8");
    end
    // R9: restart pulses keep the flag and ignore the tick
    cyc(0, 0, 0, 1, 2'd0, 8'd9, 2'd0, "R9");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, 2'd2, "R9");
    cyc(1, 1, 0, 0, 2'd0, 8'd0, 2'd1, "R9");
    idle(2'd2, "R9"); idle(2'd1, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 2'd0, 8'd0, 2'd2, "R9");
    cyc(1, 0, 1, 0, 2'd0, 8'd0, 2'd1, "R9");
    idle(2'd2, "R9"); idle(2'd0, "R9");
    // R10: read map walk including the spare address
    for (int i = 0; i < 12; i++) cyc(i % 2, 0, 0, 0, 2'd0, 8'd0, 2'(i), "R10");
    // R1: hardware reset while active
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 4; i++) idle(2'(i), "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle(2'(i), "R1");
    idle(2'd0, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule